// File: doc/BRIEF.md
# Receive Frame Stripper with Cyclic Prefix Removal

This block sits between the receiver's analog-to-digital sample stream and the forward transform stage. An external synchronizer raises a frame-start flag on the first sample of each received frame. A frame is four symbols long, and each symbol is twenty samples: four prefix samples followed by a sixteen-sample body. The block throws away the whole leading synchronization symbol. For each of the three symbols after it, the block drops the prefix and writes the body into a 48-entry sample buffer.

A read side streams each buffered symbol to the transform stage with a valid/ready handshake. It marks the final sample of every symbol, and it flags the first kept symbol of a frame as the channel-estimation symbol. A symbol is offered only after its whole body is in the buffer. The block counts frame-start flags that arrive during a capture. It raises a sticky flag when a new frame arrives before the previous one has been read out, and it drops that new frame.

Top module: `frame_strip_cp_rx`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, overrun is 0 and overlap_count is 0.
- R2: A sample is taken in only in a cycle where in_valid is 1. A frame starts on a sample that has in_valid=1 and in_frame_start=1, and that sample is position 0 of the frame. A frame-start flag with in_valid=0 has no effect.
- R3: The frame positions are counted in accepted samples. Positions 0 to 19 form the synchronization symbol, and none of them is ever output.
- R4: Positions 20..79 hold three symbols of 20. In each of them, the first 4 samples are dropped and the remaining 16 are output in arrival order.
- R5: out_valid for a kept symbol rises in the cycle after the clock edge that stores that symbol's 16th body sample. It never rises earlier.
- R6: out_sample, out_last and out_is_est hold steady while out_valid=1 and out_ready=0. A beat is transferred on a clock edge where both are 1. out_last is 1 exactly on the 16th beat of each symbol.
- R7: out_is_est is 1 on the beats of the first kept symbol of a frame and 0 on the beats of the other two kept symbols.
- R8: A frame-start flag (with in_valid=1) that arrives during positions 1..79 of a running capture is ignored. It increments overlap_count, which saturates at 255.
- R9: If a frame starts while beats of the previous kept frame are still unread, overrun becomes 1 and stays 1 until reset. That frame's positions are still counted, but none of its samples is stored. The earlier frame's output is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present on in_sample this cycle |
| in_sample | input | 14 | Received sample from the converter |
| in_frame_start | input | 1 | Synchronizer flag: this sample opens a frame |
| out_ready | input | 1 | Transform stage accepts a beat |
| out_valid | output | 1 | A buffered body sample is offered |
| out_sample | output | 14 | Body sample being offered |
| out_last | output | 1 | Beat is the final body sample of its symbol |
| out_is_est | output | 1 | Beat belongs to the channel-estimation symbol |
| overlap_count | output | 8 | Saturating count of ignored frame-start flags |
| overrun | output | 1 | Sticky: a frame arrived before the prior one drained |

## Verification
- A stored sample is visible on the output one clock after its write edge. The counters and the overrun flag change on the edge that samples the input.
- The handshake index advances on the edge of an accepted beat, so the next beat is offered in the following cycle.
- The bench keeps a behavioural model that updates on the same rising edge as the design. It compares every output at the falling edge, so each result is checked in the cycle it is due: one cycle after the 16th body write for out_valid, and one cycle after an ignored start flag for the counter.

// File: rtl/frx_pkg.sv
// Shared defaults and types for the receive frame stripper.
// Assumes: one frame = SYMS symbols, each CP prefix samples + BODY body samples.
package frx_pkg;
    localparam int unsigned SMP_W_DEF = 14;
    localparam int unsigned BODY_DEF  = 16;
    localparam int unsigned CP_DEF    = 4;
    localparam int unsigned SYMS_DEF  = 4;
    localparam int unsigned OVL_W_DEF = 8;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/frx_capture.sv
// Capture sequencer: finds the frame start, walks the frame positions,
// discards the first symbol and every prefix, and issues buffer writes.
// Also owns the overlap counter, the overrun flag and the count of
// completely written symbols of the current frame.
// Assumes: frame start is qualified by in_valid; positions advance only
// on valid samples; a frame is accepted only while the sequencer is idle.
module frx_capture
    import frx_pkg::*;
#(
    parameter int unsigned SMP_W = SMP_W_DEF,
    parameter int unsigned BODY  = BODY_DEF,
    parameter int unsigned CP    = CP_DEF,
    parameter int unsigned SYMS  = SYMS_DEF,
    parameter int unsigned OVL_W = OVL_W_DEF,
    localparam int unsigned SYM_LEN = CP + BODY,
    localparam int unsigned KEPT    = SYMS - 1,
    localparam int unsigned DEPTH   = KEPT * BODY,
    localparam int unsigned POS_W   = $clog2(SYM_LEN),
    localparam int unsigned SYM_W   = (SYMS > 2) ? $clog2(SYMS) : 1,
    localparam int unsigned ADDR_W  = $clog2(DEPTH),
    localparam int unsigned DONE_W  = $clog2(KEPT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_sample,
    input  logic              in_frame_start,
    input  logic              frame_pending,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SMP_W-1:0]  wr_data,
    output logic              frame_open,
    output logic [DONE_W-1:0] sym_done,
    output logic [OVL_W-1:0]  overlap_count,
    output logic              overrun
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SYM_LEN - 1);
    localparam logic [SYM_W-1:0] SYM_LAST = SYM_W'(SYMS - 1);
    localparam logic [OVL_W-1:0] OVL_MAX  = '1;

    cap_state_e        state_q;
    logic [SYM_W-1:0]  sym_q;
    logic [POS_W-1:0]  pos_q;
    logic              drop_q;
    logic [DONE_W-1:0] done_q;
    logic [OVL_W-1:0]  ovl_q;
    logic              ovr_q;
    logic              start_hit;

    // Purpose: decode the start event and the write of a kept body sample.
    always_comb begin
        start_hit  = in_valid && in_frame_start;
        frame_open = (state_q == CAP_IDLE) && start_hit && !frame_pending;
        wr_en      = (state_q == CAP_RUN) && in_valid && !drop_q &&
                     (sym_q != '0) && (32'(pos_q) >= CP);
        wr_addr    = ADDR_W'((32'(sym_q) - 32'd1) * BODY + (32'(pos_q) - CP));
        wr_data    = in_sample;
    end

    // Purpose: frame position sequencing, completed-symbol count and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            sym_q   <= '0;
            pos_q   <= '0;
            drop_q  <= 1'b0;
            done_q  <= '0;
            ovl_q   <= '0;
            ovr_q   <= 1'b0;
        end else if (state_q == CAP_IDLE) begin
            if (start_hit) begin
                state_q <= CAP_RUN;
                sym_q   <= '0;
                pos_q   <= POS_W'(1);
                drop_q  <= frame_pending;
                if (frame_pending) begin
                    ovr_q <= 1'b1;
                end else begin
                    done_q <= '0;
                end
            end
        end else begin
            if (in_valid) begin
                if (pos_q == POS_LAST) begin
                    pos_q <= '0;
                    if (sym_q == SYM_LAST) begin
                        state_q <= CAP_IDLE;
                    end else begin
                        sym_q <= sym_q + SYM_W'(1);
                    end
                end else begin
                    pos_q <= pos_q + POS_W'(1);
                end
                if (wr_en && (pos_q == POS_LAST)) begin
                    done_q <= done_q + DONE_W'(1);
                end
            end
            if (start_hit && (ovl_q != OVL_MAX)) begin
                ovl_q <= ovl_q + OVL_W'(1);
            end
        end
    end

    assign sym_done      = done_q;
    assign overlap_count = ovl_q;
    assign overrun       = ovr_q;
endmodule

// File: rtl/frx_sym_ram.sv
// Sample buffer holding the kept bodies of one frame.
// Synchronous write, asynchronous read: a write is visible on the next cycle.
// Assumes: the reader never addresses an entry that is not yet written.
module frx_sym_ram #(
    parameter int unsigned WIDTH = 14,
    parameter int unsigned DEPTH = 48,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Purpose: store one sample per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/frx_out_stream.sv
// Read side: offers each completely written symbol as BODY beats with a
// valid/ready handshake, marks the last beat and the estimation symbol,
// and holds the "frame pending" state until every kept beat is taken.
// Assumes: frame_open only arrives while no frame is pending.
module frx_out_stream #(
    parameter int unsigned BODY = 16,
    parameter int unsigned KEPT = 3,
    localparam int unsigned DEPTH  = KEPT * BODY,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned IDX_W  = $clog2(BODY),
    localparam int unsigned RSYM_W = (KEPT > 1) ? $clog2(KEPT) : 1,
    localparam int unsigned DONE_W = $clog2(KEPT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_open,
    input  logic [DONE_W-1:0] sym_done,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_last,
    output logic              out_is_est,
    output logic              frame_pending,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(BODY - 1);
    localparam logic [RSYM_W-1:0] RSYM_LAST = RSYM_W'(KEPT - 1);

    logic              pend_q;
    logic [RSYM_W-1:0] rsym_q;
    logic [IDX_W-1:0]  idx_q;
    logic              fire;

    // Purpose: offer a beat only from a symbol whose body is complete.
    always_comb begin
        out_valid  = pend_q && (32'(rsym_q) < 32'(sym_done));
        fire       = out_valid && out_ready;
        out_last   = (idx_q == IDX_LAST);
        out_is_est = (rsym_q == '0);
        rd_addr    = ADDR_W'(32'(rsym_q) * BODY + 32'(idx_q));
    end

    // Purpose: advance the read position on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rsym_q <= '0;
            idx_q  <= '0;
        end else if (frame_open) begin
            pend_q <= 1'b1;
            rsym_q <= '0;
            idx_q  <= '0;
        end else if (fire) begin
            if (idx_q == IDX_LAST) begin
                idx_q <= '0;
                if (rsym_q == RSYM_LAST) begin
                    rsym_q <= '0;
                    pend_q <= 1'b0;
                end else begin
                    rsym_q <= rsym_q + RSYM_W'(1);
                end
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign frame_pending = pend_q;
endmodule

// File: rtl/frame_strip_cp_rx.sv
// Top: receive frame stripper. Capture sequencer writes kept bodies into the
// buffer; the read side streams them to the transform stage.
// Assumes: the external synchronizer marks the first sample of each frame.
module frame_strip_cp_rx
    import frx_pkg::*;
#(
    parameter int unsigned SMP_W = SMP_W_DEF,
    parameter int unsigned BODY  = BODY_DEF,
    parameter int unsigned CP    = CP_DEF,
    parameter int unsigned SYMS  = SYMS_DEF,
    parameter int unsigned OVL_W = OVL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_sample,
    input  logic             in_frame_start,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_sample,
    output logic             out_last,
    output logic             out_is_est,
    output logic [OVL_W-1:0] overlap_count,
    output logic             overrun
);
    localparam int unsigned KEPT   = SYMS - 1;
    localparam int unsigned DEPTH  = KEPT * BODY;
    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam int unsigned DONE_W = $clog2(KEPT + 1);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [SMP_W-1:0]  wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              frame_open;
    logic              frame_pending;
    logic [DONE_W-1:0] sym_done;

    frx_capture #(
        .SMP_W(SMP_W), .BODY(BODY), .CP(CP), .SYMS(SYMS), .OVL_W(OVL_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sample(in_sample), .in_frame_start(in_frame_start),
        .frame_pending(frame_pending),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_open(frame_open), .sym_done(sym_done),
        .overlap_count(overlap_count), .overrun(overrun)
    );

    frx_sym_ram #(.WIDTH(SMP_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(out_sample)
    );

    frx_out_stream #(.BODY(BODY), .KEPT(KEPT)) u_out (
        .clk(clk), .rst_n(rst_n),
        .frame_open(frame_open), .sym_done(sym_done), .out_ready(out_ready),
        .out_valid(out_valid), .out_last(out_last), .out_is_est(out_is_est),
        .frame_pending(frame_pending), .rd_addr(rd_addr)
    );
endmodule

// File: rtl/frx_checker.sv
// Checker for the receive frame stripper, bound to the top module.
// Tracks beat and symbol position from the handshake alone.
module frx_checker #(
    parameter int unsigned SMP_W = 14,
    parameter int unsigned BODY  = 16,
    parameter int unsigned SYMS  = 4,
    parameter int unsigned OVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [SMP_W-1:0] out_sample,
    input logic             out_last,
    input logic             out_is_est,
    input logic [OVL_W-1:0] overlap_count,
    input logic             overrun
);
    localparam int unsigned KEPT = SYMS - 1;
    int unsigned beat_q;
    int unsigned ksym_q;

    // Purpose: follow beat index within a symbol and symbol index within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= 0;
            ksym_q <= 0;
        end else if (out_valid && out_ready) begin
            if (beat_q == BODY - 1) begin
                beat_q <= 0;
                ksym_q <= (ksym_q == KEPT - 1) ? 0 : ksym_q + 1;
            end else begin
                beat_q <= beat_q + 1;
            end
        end
    end

    a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) &&
                                       $stable(out_last) && $stable(out_is_est)));

    a_r6_last_on_final_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (beat_q == BODY - 1)));

    a_r7_est_first_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_is_est == (ksym_q == 0)));

    a_r8_ovl_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (&overlap_count) |=> (&overlap_count));

    a_r8_ovl_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (overlap_count >= $past(overlap_count)));

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind frame_strip_cp_rx frx_checker #(
    .SMP_W(SMP_W), .BODY(BODY), .SYMS(SYMS), .OVL_W(OVL_W)
) u_frx_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .out_last(out_last), .out_is_est(out_is_est),
    .overlap_count(overlap_count), .overrun(overrun)
);

// File: tb/tb_frame_strip_cp_rx.sv
// Bench: behavioural frame model updated on each rising edge, all outputs
// compared on each falling edge.
module tb_frame_strip_cp_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic        in_frame_start = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [13:0] out_sample;
    logic        out_last;
    logic        out_is_est;
    logic [7:0]  overlap_count;
    logic        overrun;

    int checks = 0;
    int fails  = 0;
    int ready_mode = 1;   // 0: never ready, 1: always, 2: random
    bit finished = 1'b0;

    // behavioural model state
    bit m_busy, m_drop, m_ovr, m_hf;
    int m_k, m_ovl, m_written, m_read;
    int mem [48];
    int beats_seen = 0;

    always #10 clk = ~clk;

    frame_strip_cp_rx dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_frame_start(in_frame_start), .out_ready(out_ready),
        .out_valid(out_valid), .out_sample(out_sample), .out_last(out_last),
        .out_is_est(out_is_est), .overlap_count(overlap_count), .overrun(overrun)
    );

    function automatic bit exp_valid();
        return m_hf && ((m_read / 16) < (m_written / 16));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_drop = 0; m_ovr = 0; m_hf = 0;
            m_k = 0; m_ovl = 0; m_written = 0; m_read = 0;
        end else begin
            bit fire;
            bit hf_pre;
            fire   = exp_valid() && out_ready;
            hf_pre = m_hf;
            if (!m_busy) begin
                if (in_valid && in_frame_start) begin
                    m_busy = 1; m_k = 1; m_drop = hf_pre;
                    if (hf_pre) m_ovr = 1;
                    else begin m_written = 0; m_hf = 1; m_read = 0; end
                end
            end else if (in_valid) begin
                if (in_frame_start && m_ovl < 255) m_ovl++;
                if (!m_drop && m_k >= 20 && (m_k % 20) >= 4) begin
                    mem[(m_k / 20 - 1) * 16 + (m_k % 20) - 4] = int'(in_sample);
                    m_written++;
                end
                m_k++;
                if (m_k == 80) m_busy = 0;
            end
            if (fire) begin
                beats_seen++;
                m_read++;
                if (m_read == 48) begin m_read = 0; m_hf = 0; end
            end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ev;
            ev = exp_valid();
            chk(out_valid == ev, "R5 out_valid timing", int'(out_valid), int'(ev));
            if (ev) begin
                chk(int'(out_sample) == mem[m_read], "R4 body sample order", int'(out_sample), mem[m_read]);
                chk(out_last == ((m_read % 16) == 15), "R6 last flag", int'(out_last), int'((m_read % 16) == 15));
                chk(out_is_est == (m_read < 16), "R7 estimation tag", int'(out_is_est), int'(m_read < 16));
            end
            chk(int'(overlap_count) == m_ovl, "R8 overlap count", int'(overlap_count), m_ovl);
            chk(overrun == m_ovr, "R9 overrun flag", int'(overrun), int'(m_ovr));
        end
    end

    // Ready driver.
    always @(negedge clk) begin
        case (ready_mode)
            0:       out_ready <= 1'b0;
            1:       out_ready <= 1'b1;
            default: out_ready <= 1'($urandom_range(0, 1));
        endcase
    end

    // Sends one frame of 80 valid samples; value = base + position.
    // extra_at >= 0 raises the start flag again at that position; hold raises it on all.
    task automatic send_frame(input int base, input int gap_pct, input int extra_at, input bit hold);
        for (int k = 0; k < 80; k++) begin
            while (gap_pct > 0 && $urandom_range(0, 99) < gap_pct) begin
                @(negedge clk);
                in_valid <= 1'b0; in_frame_start <= 1'b1;  // R2: start with no valid is ignored
            end
            @(negedge clk);
            in_valid       <= 1'b1;
            in_sample      <= 14'(base + k);
            in_frame_start <= (k == 0) || (k == extra_at) || hold;
        end
        @(negedge clk);
        in_valid <= 1'b0; in_frame_start <= 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid <= 1'b0; in_frame_start <= 1'b0;
        end
    endtask

    initial begin
        int b0;
        repeat (5) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(overrun == 1'b0, "R1 reset overrun", int'(overrun), 0);
        chk(overlap_count == 8'd0, "R1 reset overlap_count", int'(overlap_count), 0);

        // R3 R4: continuous frame, always ready
        ready_mode = 1;
        send_frame(1000, 0, -1, 0);
        idle(60);
        chk(beats_seen == 48, "R3 R4 beats per frame", beats_seen, 48);

        // R2 R6: gaps on input, random ready
        ready_mode = 2;
        send_frame(3000, 30, -1, 0);
        idle(150);
        chk(beats_seen == 96, "R2 R6 beats after gapped frame", beats_seen, 96);

        // R8: one extra start flag mid frame
        ready_mode = 1;
        send_frame(5000, 0, 30, 0);
        idle(60);
        chk(overlap_count == 8'd1, "R8 single overlap counted", int'(overlap_count), 1);

        // R9: stall output, second frame arrives undrained
        ready_mode = 0;
        send_frame(7000, 0, -1, 0);
        idle(5);
        send_frame(9000, 0, -1, 0);
        idle(5);
        chk(overrun == 1'b1, "R9 overrun raised", int'(overrun), 1);
        b0 = beats_seen;
        ready_mode = 1;
        idle(60);
        chk(beats_seen - b0 == 48, "R9 prior frame intact", beats_seen - b0, 48);

        // R9 recovery and R8 saturation
        send_frame(11000, 0, -1, 0);
        idle(60);
        for (int f = 0; f < 4; f++) begin
            send_frame(12000 + f * 100, 0, -1, 1);
            idle(60);
        end
        chk(overlap_count == 8'd255, "R8 overlap saturates", int'(overlap_count), 255);
        chk(overrun == 1'b1, "R9 overrun still sticky", int'(overrun), 1);

        // R2: start flags with in_valid low start nothing
        b0 = beats_seen;
        repeat (30) begin
            @(negedge clk);
            in_valid <= 1'b0; in_frame_start <= 1'b1;
        end
        idle(40);
        chk(beats_seen == b0, "R2 unqualified start ignored", beats_seen - b0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule